// File: doc/BRIEF.md
# Timed Interrupt Hold-Off Counter

This block holds off the lower user interrupt levels for a set number of instruction cycles, so that a short, time-critical code sequence runs without being preempted. A start command loads a 14-bit count. While that count is nonzero, the block asserts a mask for priority levels 1 to 6 toward the interrupt arbiter. It also raises a status bit. Level 7 requests and all traps are never masked by this block. The count drops by one on every cycle in which the instruction-cycle enable is high, including stall cycles. When the count reaches zero, the mask is released.

Software can read the live count. It can also change an active window through a small register port. A set operation replaces the count, and setting zero ends the window at once. An add operation lengthens the window and saturates at the counter maximum. Such port writes only modify a window that is already open. Writing while the count is zero does nothing, so only the start command can open a window.

Top module: `irq_hold_timer`

## Requirements
- R1: After reset the count is 0, the status bit is 0 and no mask bit is set.
- R2: A start command loads `start_cnt_i` into the count at the next clock edge. From then on, while the count is nonzero, the status bit is 1.
- R3: With no start and no port write, each cycle with `cyc_en_i` high lowers a nonzero count by exactly one. A cycle with `cyc_en_i` low leaves the count unchanged.
- R4: When the count reaches 0, the status bit and the level 1–6 mask fall at that same edge. The count then stays at 0 while the enable keeps running.
- R5: `lvl_mask_o` bit i stands for priority level i+1. Bits 0 to 5 equal the status bit. Bit 6 (level 7) is always 0.
- R6: A port write with `wr_op_i`=0 (set) while the count is nonzero replaces the count with `wr_data_i`. Setting 0 ends the window at the next edge.
- R7: A port write with `wr_op_i`=1 (add) while the count is nonzero adds `wr_data_i` to the count. The result saturates at 16383.
- R8: A port write of any operation or value while the count is 0 leaves the count at 0 and the mask low.
- R9: When a start command and a port write arrive in the same cycle, the start value is loaded and the write is dropped. A start with a count of 0 leaves the block idle.
- R10: In a cycle that carries a start command or an accepted port write, `cyc_en_i` causes no decrement; the loaded or written value is taken as is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | One pulse per instruction cycle, stalls included |
| start_i | input | 1 | Start command, opens a hold-off window |
| start_cnt_i | input | 14 | Cycle count loaded by the start command |
| wr_en_i | input | 1 | Port write strobe |
| wr_op_i | input | 1 | 0 = set count, 1 = add to count |
| wr_data_i | input | 14 | Port write operand |
| cnt_o | output | 14 | Live count readback |
| active_o | output | 1 | Status: masking active |
| lvl_mask_o | output | 7 | Mask per priority level, bit i = level i+1 |

## Verification
Every result is due one clock edge after the stimulus that causes it. A single register lies between any input and `cnt_o`, `active_o` and `lvl_mask_o`. The bench drives inputs on the falling edge and lets one rising edge pass. It then reads all three outputs on the following falling edge, so each check sees exactly the state produced by that edge. Countdown checks repeat this once per enabled cycle and compare against a count the bench keeps itself. Boundary checks also use the cycle in which the count reaches zero, so the mask must already be low there.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;
  typedef enum logic {
    WR_SET = 1'b0,
    WR_ADD = 1'b1
  } wr_op_e;
endpackage

// File: rtl/irq_hold_next.sv
module irq_hold_next #(
  parameter int unsigned CNT_W = 14
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cyc_en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic             wr_en_i,
  input  irq_hold_pkg::wr_op_e wr_op_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             armed;
  logic [CNT_W:0]   sum;

  assign armed = |cnt_i;
  assign sum   = {1'b0, cnt_i} + {1'b0, wr_data_i};

  always_comb begin
    cnt_nxt_o = cnt_i;
    if (start_i) begin
      cnt_nxt_o = start_cnt_i;
    end else if (wr_en_i) begin
      // port writes only touch an open window
      if (armed) begin
        if (wr_op_i == irq_hold_pkg::WR_ADD)
          cnt_nxt_o = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        else
          cnt_nxt_o = wr_data_i;
      end
    end else if (cyc_en_i && armed) begin
      cnt_nxt_o = cnt_i - 1'b1;
    end
  end
endmodule

// File: rtl/irq_hold_cnt.sv
module irq_hold_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_nxt_i;
  end
endmodule

// File: rtl/irq_hold_mask.sv
module irq_hold_mask #(
  parameter int unsigned NUM_LVL  = 7,
  parameter int unsigned MASK_TOP = 6
) (
  input  logic               hold_i,
  output logic [NUM_LVL-1:0] lvl_mask_o
);
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    if (i + 1 <= MASK_TOP) begin : g_on
      assign lvl_mask_o[i] = hold_i;
    end else begin : g_off
      assign lvl_mask_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer #(
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned NUM_LVL  = 7,
  parameter int unsigned MASK_TOP = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_en_i,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   start_cnt_i,
  input  logic               wr_en_i,
  input  logic               wr_op_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               active_o,
  output logic [NUM_LVL-1:0] lvl_mask_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  irq_hold_pkg::wr_op_e op;

  assign op = irq_hold_pkg::wr_op_e'(wr_op_i);

  irq_hold_next #(.CNT_W(CNT_W)) u_next (
    .cnt_i      (cnt_q),
    .cyc_en_i   (cyc_en_i),
    .start_i    (start_i),
    .start_cnt_i(start_cnt_i),
    .wr_en_i    (wr_en_i),
    .wr_op_i    (op),
    .wr_data_i  (wr_data_i),
    .cnt_nxt_o  (cnt_d)
  );

  irq_hold_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_nxt_i(cnt_d),
    .cnt_o    (cnt_q)
  );

  assign cnt_o    = cnt_q;
  assign active_o = |cnt_q;

  irq_hold_mask #(.NUM_LVL(NUM_LVL), .MASK_TOP(MASK_TOP)) u_mask (
    .hold_i    (active_o),
    .lvl_mask_o(lvl_mask_o)
  );
endmodule

// File: rtl/irq_hold_chk.sv
module irq_hold_chk #(
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned NUM_LVL  = 7,
  parameter int unsigned MASK_TOP = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cyc_en_i,
  input logic               start_i,
  input logic [CNT_W-1:0]   start_cnt_i,
  input logic               wr_en_i,
  input logic               wr_op_i,
  input logic [CNT_W-1:0]   wr_data_i,
  input logic [CNT_W-1:0]   cnt_o,
  input logic               active_o,
  input logic [NUM_LVL-1:0] lvl_mask_o
);
  // R2 R9 R10
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_o == $past(start_cnt_i));

  // R3
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !wr_en_i && cyc_en_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !wr_en_i && !cyc_en_i) |=> $stable(cnt_o));

  // R4
  stay_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_o == '0) |=> (cnt_o == '0 && !active_o));

  // R5
  top_lvl_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_mask_o[NUM_LVL-1]);

  // R5
  low_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_mask_o[MASK_TOP-1] == active_o && lvl_mask_o[0] == active_o);

  // R6
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && wr_en_i && !wr_op_i && cnt_o != '0) |=> cnt_o == $past(wr_data_i));

  // R7
  add_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && wr_en_i && wr_op_i && cnt_o != '0) |=> cnt_o >= $past(cnt_o));
endmodule

bind irq_hold_timer irq_hold_chk #(
  .CNT_W(CNT_W), .NUM_LVL(NUM_LVL), .MASK_TOP(MASK_TOP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i), .start_i(start_i),
  .start_cnt_i(start_cnt_i), .wr_en_i(wr_en_i), .wr_op_i(wr_op_i),
  .wr_data_i(wr_data_i), .cnt_o(cnt_o), .active_o(active_o),
  .lvl_mask_o(lvl_mask_o)
);

// File: tb/sim_irq_hold_timer.sv
module sim_irq_hold_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 14;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0, start = 1'b0, wr_en = 1'b0, wr_op = 1'b0;
  logic [CNT_W-1:0] start_cnt = '0, wr_data = '0;
  logic [CNT_W-1:0] cnt;
  logic active;
  logic [6:0] mask;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hold_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .start_i(start),
    .start_cnt_i(start_cnt), .wr_en_i(wr_en), .wr_op_i(wr_op),
    .wr_data_i(wr_data), .cnt_o(cnt), .active_o(active), .lvl_mask_o(mask)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // checks count, status and mask together
  task automatic check_state(input string tag, input int exp_cnt);
    check({tag, " cnt"}, int'(cnt), exp_cnt);
    check({tag, " active"}, int'(active), exp_cnt != 0);
    check({tag, " mask"}, int'(mask), exp_cnt != 0 ? 7'h3F : 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0; cyc_en = 1'b0;
  endtask

  task automatic do_start(input int n, input logic en);
    start = 1'b1; start_cnt = CNT_W'(n); cyc_en = en; tick();
  endtask

  task automatic do_wr(input logic op, input int d, input logic en);
    wr_en = 1'b1; wr_op = op; wr_data = CNT_W'(d); cyc_en = en; tick();
  endtask

  task automatic t_reset();
    check_state("R1 reset", 0);
  endtask

  task automatic t_countdown();
    do_start(4, 1'b0);
    check_state("R2 start", 4);
    check("R5 level7 clear", int'(mask[6]), 0);
    for (int k = 3; k >= 1; k--) begin
      cyc_en = 1'b1; tick();
      check_state("R3 dec", k);
    end
    tick();
    check_state("R3 hold without enable", 1);
    cyc_en = 1'b1; tick();
    check_state("R4 reach zero", 0);
    for (int k = 0; k < 3; k++) begin
      cyc_en = 1'b1; tick();
    end
    check_state("R4 stays zero", 0);
  endtask

  task automatic t_idle_write();
    do_wr(1'b0, 50, 1'b0);
    check_state("R8 set while idle", 0);
    do_wr(1'b1, 50, 1'b0);
    check_state("R8 add while idle", 0);
  endtask

  task automatic t_modify();
    do_start(10, 1'b0);
    do_wr(1'b0, 3, 1'b1);
    check_state("R6 set replaces R10", 3);
    do_wr(1'b1, 4, 1'b1);
    check_state("R7 add R10", 7);
    do_wr(1'b0, 16000, 1'b0);
    do_wr(1'b1, 1000, 1'b0);
    check_state("R7 saturate", MAXV);
    do_wr(1'b0, 0, 1'b0);
    check_state("R6 set zero ends", 0);
  endtask

  task automatic t_priority();
    start = 1'b1; start_cnt = CNT_W'(20);
    wr_en = 1'b1; wr_op = 1'b0; wr_data = CNT_W'(5);
    tick();
    check_state("R9 start beats write", 20);
    do_start(9, 1'b1);
    check_state("R10 start no dec", 9);
    do_start(0, 1'b0);
    check_state("R9 start zero", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_countdown();
    t_idle_write();
    t_modify();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule